// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block keeps the interrupt presentation state of a single processor and decides which interrupt, if any, that processor is asked to take. It holds the current processor priority, a 24-bit pending source number, the priority of that pending interrupt and a software inter-processor-interrupt (IPI) request priority. Source controllers offer interrupts to it one at a time. It either takes an offer or hands it back as rejected. When a more favoured interrupt displaces one that a source delivered, the displaced one is handed back to that source, so the source can offer it again later.

The processor side reaches the block through register operations: accept, poll, set processor priority, set IPI priority and end-of-interrupt. A single level output tells the processor that something is pending. A smaller priority number is more favoured, and 0xFF means "least favoured" or "none". Rejections, end-of-interrupt notices and resend requests leave the block as single-cycle pulses toward the source layer.

Top module: `irq_presenter`

## Requirements
- R1: After reset the pending register (processor priority in bits 31:24, pending source in bits 23:0) reads as zero, the IPI priority reads as 0xFF and `cpu_irq` is low.
- R2: An offer is rejected when its priority is greater than or equal to the processor priority, or when something is pending (nonzero source field) whose pending priority is less than or equal to the offered priority. The rejection appears one cycle later as a `rej_valid` pulse carrying the offered source number.
- R3: An offer that is not rejected becomes the pending source, its priority becomes the pending priority and `cpu_irq` goes high. A displaced pending interrupt that came from a source is rejected in the same pulse. A displaced IPI is not rejected.
- R4: Accept (op code 1) returns the pending register in `rd_data`, lowers `cpu_irq`, loads the processor priority with the pending priority, clears the source field and sets the pending priority to 0xFF.
- R5: Poll (op code 2) returns the pending register in `rd_data` and the IPI priority in `rd_mfrr`, and changes no state.
- R6: Set processor priority (op code 3, value in `op_data[7:0]`) to a more favoured value that is less than or equal to the pending priority clears the pending source, lowers `cpu_irq` and rejects the interrupt if a source delivered it. A more favoured value above the pending priority keeps the interrupt pending.
- R7: Set processor priority to an equal or less favoured value while nothing is pending pulses `resend_req`. If the IPI priority is then below the new processor priority, the IPI is presented.
- R8: Set IPI priority (op code 4, value in `op_data[7:0]`) below the processor priority presents source number 2 with the IPI priority as pending priority and raises `cpu_irq`. Nothing changes if the pending priority is already less than or equal to the new IPI priority, or if the value is not below the processor priority.
- R9: End-of-interrupt (op code 5) copies `op_data[31:24]` into the processor priority and pulses `eoi_valid` with `op_data[23:0]`. If nothing is pending, it pulses `resend_req` and presents the IPI when the IPI priority is below the new processor priority.
- R10: An offer presented in the same cycle as a register operation is ignored. Op codes 0, 6 and 7 have no effect.
- R11: All results, pulses and `cpu_irq` are registered and change in the cycle after the operation or offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 3 | Operation selector (1 accept, 2 poll, 3 set priority, 4 set IPI priority, 5 end-of-interrupt) |
| op_data | input | 32 | Operation operand |
| offer_valid | input | 1 | Interrupt offer strobe from the source layer |
| offer_src | input | 24 | Offered source number (nonzero) |
| offer_prio | input | 8 | Offered priority |
| rd_valid | output | 1 | Pulse: read result updated |
| rd_data | output | 32 | Pending register returned by accept or poll |
| rd_mfrr | output | 8 | IPI priority returned by poll |
| rej_valid | output | 1 | Pulse: an interrupt is handed back |
| rej_src | output | 24 | Source number handed back |
| eoi_valid | output | 1 | Pulse: end-of-interrupt forwarded |
| eoi_src | output | 24 | Source number ending service |
| resend_req | output | 1 | Pulse: sources should re-offer rejected interrupts |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is an IPI pending together with a source interrupt that displaces it, or that it displaces. Only the second case may produce a rejection. The bench builds it with an ordered script: it raises the IPI priority, offers a more favoured source interrupt, then writes ever more favoured IPI priorities. It then lowers the processor priority below the IPI and ends service with a nothing-pending state, so the IPI reappears through the resend path. Sweeps over the offered priority against three processor priorities, and over the IPI priority against one, cover the accept-or-reject boundary at every step.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W = 24,
  parameter int PRIO_W = 8,
  parameter int OP_W = 3,
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [OP_W-1:0]         op_code,
  input  logic [SRC_W+PRIO_W-1:0] op_data,
  input  logic                    offer_valid,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRIO_W-1:0]       offer_prio,
  output logic                    rd_valid,
  output logic [SRC_W+PRIO_W-1:0] rd_data,
  output logic [PRIO_W-1:0]       rd_mfrr,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req,
  output logic                    cpu_irq
);
  localparam int REG_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] NONE = '1;
  localparam logic [OP_W-1:0] OP_ACCEPT = 1;
  localparam logic [OP_W-1:0] OP_POLL   = 2;
  localparam logic [OP_W-1:0] OP_CPPR   = 3;
  localparam logic [OP_W-1:0] OP_MFRR   = 4;
  localparam logic [OP_W-1:0] OP_EOI    = 5;

  logic [PRIO_W-1:0] cppr, pend, mfrr;
  logic [SRC_W-1:0]  xisr;
  logic              owned;

  logic [PRIO_W-1:0] n_cppr, n_pend, n_mfrr;
  logic [SRC_W-1:0]  n_xisr;
  logic              n_owned, n_irq;
  logic              n_rej, n_eoi, n_resend, n_rd;
  logic [SRC_W-1:0]  n_rej_src, n_eoi_src;
  logic [REG_W-1:0]  n_rd_data;
  logic [PRIO_W-1:0] n_rd_mfrr;
  logic              ipi_go;

  wire               busy   = xisr != '0;
  wire [PRIO_W-1:0]  op_pri = op_data[PRIO_W-1:0];
  wire [PRIO_W-1:0]  op_top = op_data[REG_W-1:SRC_W];

  always_comb begin
    n_cppr    = cppr;
    n_xisr    = xisr;
    n_pend    = pend;
    n_mfrr    = mfrr;
    n_owned   = owned;
    n_irq     = cpu_irq;
    n_rej     = 1'b0;
    n_rej_src = '0;
    n_eoi     = 1'b0;
    n_eoi_src = '0;
    n_resend  = 1'b0;
    n_rd      = 1'b0;
    n_rd_data = rd_data;
    n_rd_mfrr = rd_mfrr;
    ipi_go    = 1'b0;

    if (op_valid) begin
      case (op_code)
        OP_ACCEPT: begin
          n_rd      = 1'b1;
          n_rd_data = {cppr, xisr};
          n_rd_mfrr = mfrr;
          n_irq     = 1'b0;
          n_cppr    = pend;
          n_xisr    = '0;
          n_pend    = NONE;
          n_owned   = 1'b0;
        end
        OP_POLL: begin
          n_rd      = 1'b1;
          n_rd_data = {cppr, xisr};
          n_rd_mfrr = mfrr;
        end
        OP_CPPR: begin
          n_cppr = op_pri;
          if (op_pri < cppr) begin
            if (busy && op_pri <= pend) begin
              n_xisr  = '0;
              n_pend  = NONE;
              n_irq   = 1'b0;
              n_owned = 1'b0;
              if (owned) begin
                n_rej     = 1'b1;
                n_rej_src = xisr;
              end
            end
          end else if (!busy) begin
            n_resend = 1'b1;
            ipi_go   = mfrr < op_pri;
          end
        end
        OP_MFRR: begin
          n_mfrr = op_pri;
          ipi_go = op_pri < cppr;
        end
        OP_EOI: begin
          n_cppr    = op_top;
          n_eoi     = 1'b1;
          n_eoi_src = op_data[SRC_W-1:0];
          if (!busy) begin
            n_resend = 1'b1;
            ipi_go   = mfrr < op_top;
          end
        end
        default: ;
      endcase
    end else if (offer_valid) begin
      if (offer_prio >= cppr || (busy && pend <= offer_prio)) begin
        n_rej     = 1'b1;
        n_rej_src = offer_src;
      end else begin
        if (busy && owned) begin
          n_rej     = 1'b1;
          n_rej_src = xisr;
        end
        n_xisr  = offer_src;
        n_pend  = offer_prio;
        n_owned = 1'b1;
        n_irq   = 1'b1;
      end
    end

    if (ipi_go && !(n_xisr != '0 && n_pend <= n_mfrr)) begin
      if (n_xisr != '0 && n_owned) begin
        n_rej     = 1'b1;
        n_rej_src = n_xisr;
      end
      n_xisr  = IPI_SRC;
      n_pend  = n_mfrr;
      n_owned = 1'b0;
      n_irq   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr       <= '0;
      xisr       <= '0;
      pend       <= NONE;
      mfrr       <= NONE;
      owned      <= 1'b0;
      cpu_irq    <= 1'b0;
      rej_valid  <= 1'b0;
      rej_src    <= '0;
      eoi_valid  <= 1'b0;
      eoi_src    <= '0;
      resend_req <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_mfrr    <= NONE;
    end else begin
      cppr       <= n_cppr;
      xisr       <= n_xisr;
      pend       <= n_pend;
      mfrr       <= n_mfrr;
      owned      <= n_owned;
      cpu_irq    <= n_irq;
      rej_valid  <= n_rej;
      rej_src    <= n_rej_src;
      eoi_valid  <= n_eoi;
      eoi_src    <= n_eoi_src;
      resend_req <= n_resend;
      rd_valid   <= n_rd;
      rd_data    <= n_rd_data;
      rd_mfrr    <= n_rd_mfrr;
    end
  end
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk #(
  parameter int SRC_W = 24,
  parameter int PRIO_W = 8,
  parameter int OP_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid,
  input logic [OP_W-1:0]         op_code,
  input logic [SRC_W+PRIO_W-1:0] op_data,
  input logic                    offer_valid,
  input logic [SRC_W-1:0]        offer_src,
  input logic [PRIO_W-1:0]       offer_prio,
  input logic                    cpu_irq,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic [PRIO_W-1:0]       cppr,
  input logic [PRIO_W-1:0]       pend,
  input logic [SRC_W-1:0]        xisr
);
  localparam int REG_W = SRC_W + PRIO_W;

  // R4
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 1 |=> !cpu_irq && xisr == '0 && cppr == $past(pend));

  // R5
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 2 |=> $stable(xisr) && $stable(cppr) && $stable(pend) && !rej_valid);

  // R2
  weak_offer_bounce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && offer_valid && offer_prio >= cppr
      |=> rej_valid && rej_src == $past(offer_src) && $stable(xisr));

  // R3
  strong_offer_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && offer_valid && offer_prio < cppr && (xisr == '0 || pend > offer_prio)
      |=> cpu_irq && xisr == $past(offer_src));

  // R9
  eoi_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 5
      |=> eoi_valid && eoi_src == $past(op_data[SRC_W-1:0]) && cppr == $past(op_data[REG_W-1:SRC_W]));
endmodule

bind irq_presenter irq_presenter_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
  .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
  .cpu_irq(cpu_irq), .rej_valid(rej_valid), .rej_src(rej_src),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src), .cppr(cppr), .pend(pend), .xisr(xisr));

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        rd_valid, rej_valid, eoi_valid, resend_req, cpu_irq;
  logic [31:0] rd_data;
  logic [7:0]  rd_mfrr;
  logic [23:0] rej_src, eoi_src;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_mfrr(rd_mfrr),
    .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend_req(resend_req), .cpu_irq(cpu_irq));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] c, input logic [31:0] d);
    op_valid = 1'b1; op_code = c; op_data = d;
    @(posedge clk); #1;
    op_valid = 1'b0; op_code = '0; op_data = '0;
  endtask

  task automatic offer(input logic [23:0] s, input logic [7:0] p);
    offer_valid = 1'b1; offer_src = s; offer_prio = p;
    @(posedge clk); #1;
    offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
  endtask

  task automatic poll(input string rq, input logic [31:0] exp);
    op(3'd2, 32'h0);
    chk(rq, rd_data, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'b0, cpu_irq}, 32'h0);
    op(3'd2, 32'h0);
    chk("R1 reg", rd_data, 32'h0);
    chk("R1 mfrr", {24'h0, rd_mfrr}, 32'hFF);
    chk("R11 rd_valid", {31'b0, rd_valid}, 32'h1);

    // R2 R3 R4 R9 sweep: offered priority against processor priority
    for (int ci = 0; ci < 3; ci++) begin
      logic [7:0] c;
      c = (ci == 0) ? 8'h10 : (ci == 1) ? 8'h80 : 8'hFF;
      op(3'd3, {24'h0, c});
      for (int p = 0; p < 256; p += 15) begin
        logic [23:0] s;
        s = 24'h1000 + 24'(p);
        offer(s, 8'(p));
        if (p >= c) begin
          chk("R2 reject", {31'b0, rej_valid}, 32'h1);
          chk("R2 rej_src", {8'h0, rej_src}, {8'h0, s});
          chk("R2 irq low", {31'b0, cpu_irq}, 32'h0);
        end else begin
          chk("R3 taken", {31'b0, rej_valid}, 32'h0);
          chk("R3 irq", {31'b0, cpu_irq}, 32'h1);
          op(3'd1, 32'h0);
          chk("R4 accept data", rd_data, {c, s});
          chk("R4 irq low", {31'b0, cpu_irq}, 32'h0);
          poll("R4 cppr from pending", {8'(p), 24'h0});
          op(3'd5, {c, s});
          chk("R9 eoi pulse", {31'b0, eoi_valid}, 32'h1);
          chk("R9 eoi src", {8'h0, eoi_src}, {8'h0, s});
          chk("R9 resend", {31'b0, resend_req}, 32'h1);
        end
      end
    end

    // R2 R3 displacement; processor priority is FF
    offer(24'hA, 8'h40);
    chk("R3 take A", {31'b0, cpu_irq}, 32'h1);
    offer(24'hB, 8'h40);
    chk("R2 equal pending", {rej_valid, 7'b0, rej_src}, {1'b1, 7'b0, 24'hB});
    offer(24'hB, 8'h30);
    chk("R3 displaced A", {rej_valid, 7'b0, rej_src}, {1'b1, 7'b0, 24'hA});
    poll("R3 pending B", {8'hFF, 24'hB});
    offer(24'hC, 8'h50);
    chk("R2 weaker than pending", {rej_valid, 7'b0, rej_src}, {1'b1, 7'b0, 24'hC});

    // R6 R7
    op(3'd3, 32'h50);
    chk("R6 kept", {30'b0, rej_valid, cpu_irq}, 32'h1);
    poll("R6 kept reg", {8'h50, 24'hB});
    op(3'd3, 32'h30);
    chk("R6 bounce", {rej_valid, 7'b0, rej_src}, {1'b1, 7'b0, 24'hB});
    chk("R6 irq low", {31'b0, cpu_irq}, 32'h0);
    poll("R6 cleared", {8'h30, 24'h0});
    op(3'd3, 32'h40);
    chk("R7 resend", {30'b0, resend_req, rej_valid}, 32'h2);
    poll("R7 reg", {8'h40, 24'h0});

    // R8 IPI interplay
    op(3'd3, 32'hFF);
    op(3'd4, 32'h60);
    chk("R8 ipi raise", {30'b0, rej_valid, cpu_irq}, 32'h1);
    op(3'd2, 32'h0);
    chk("R8 ipi reg", rd_data, {8'hFF, 24'h2});
    chk("R5 mfrr", {24'h0, rd_mfrr}, 32'h60);
    offer(24'h9, 8'h50);
    chk("R3 ipi displaced silently", {30'b0, rej_valid, cpu_irq}, 32'h1);
    poll("R3 pending 9", {8'hFF, 24'h9});
    op(3'd4, 32'h55);
    chk("R8 no change", {31'b0, rej_valid}, 32'h0);
    poll("R8 still 9", {8'hFF, 24'h9});
    op(3'd4, 32'h40);
    chk("R8 bounce 9", {rej_valid, 7'b0, rej_src}, {1'b1, 7'b0, 24'h9});
    poll("R8 ipi back", {8'hFF, 24'h2});
    op(3'd3, 32'h30);
    chk("R6 ipi cleared no reject", {30'b0, rej_valid, cpu_irq}, 32'h0);
    op(3'd4, 32'h35);
    chk("R8 above cppr irq", {31'b0, cpu_irq}, 32'h0);
    poll("R8 above cppr", {8'h30, 24'h0});

    // R9 IPI through end-of-interrupt
    op(3'd5, 32'hFF000123);
    chk("R9 eoi", {eoi_valid, 7'b0, eoi_src}, {1'b1, 7'b0, 24'h123});
    chk("R9 resend ipi", {30'b0, resend_req, cpu_irq}, 32'h3);
    op(3'd2, 32'h0);
    chk("R9 reg", rd_data, {8'hFF, 24'h2});
    chk("R9 mfrr", {24'h0, rd_mfrr}, 32'h35);
    op(3'd1, 32'h0);
    chk("R4 accept ipi", rd_data, {8'hFF, 24'h2});
    poll("R4 after ipi", {8'h35, 24'h0});

    // R10 ignored stimulus
    offer_valid = 1'b1; offer_src = 24'h77; offer_prio = 8'h00;
    op(3'd2, 32'h0);
    offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
    chk("R10 concurrent offer", {30'b0, rej_valid, cpu_irq}, 32'h0);
    poll("R10 state unchanged", {8'h35, 24'h0});
    op(3'd7, 32'hFFFFFFFF);
    op(3'd0, 32'h00000000);
    op(3'd6, 32'h12345678);
    chk("R10 bad code", {29'b0, rd_valid, rej_valid, cpu_irq}, 32'h0);
    poll("R10 bad code state", {8'h35, 24'h0});

    // R8 sweep of IPI priority against processor priority 0x80
    op(3'd4, 32'hFF);
    op(3'd3, 32'h80);
    for (int m = 0; m < 256; m += 16) begin
      op(3'd4, 32'(m));
      chk("R8 sweep irq", {31'b0, cpu_irq}, {31'b0, m < 8'h80});
      if (m < 8'h80) begin
        op(3'd1, 32'h0);
        chk("R8 sweep accept", rd_data, {8'h80, 24'h2});
        op(3'd4, 32'hFF);
        op(3'd5, {8'h80, 24'h2});
      end else begin
        poll("R8 sweep none", {8'h80, 24'h0});
      end
    end

    // R7 IPI via priority relaxation
    op(3'd3, 32'h10);
    op(3'd4, 32'h20);
    poll("R7 no ipi yet", {8'h10, 24'h0});
    op(3'd3, 32'h40);
    chk("R7 resend ipi", {30'b0, resend_req, cpu_irq}, 32'h3);
    poll("R7 ipi reg", {8'h40, 24'h2});

    summary();
  end
endmodule